// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the memory operand address for a 16-bit processor whose address registers are 32 bits wide and whose address space is 24 bits. On each clock it takes an addressing-mode code, an access size, the contents of the selected address register and the immediate field of the instruction. One cycle later it presents the 24-bit operand address and the value to store back into the address register. It also shows whether that store-back is needed and whether a multi-byte access falls on an odd address.

It covers eight addressing forms: plain register indirect, register plus a 16-bit or 24-bit displacement, auto-increment after the access, auto-decrement before the access, and absolute addresses 8, 16 or 24 bits long. The two auto-update forms change the register by a step that depends on the access size, and they wrap across the full 32 bits. The two short absolute forms are widened differently. The 8-bit form is padded with ones. The 16-bit form is sign-extended. Instruction decode, the register file and the bus are outside the block.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 3'd0 (register indirect) gives an address equal to bits 23:0 of the register input.
- R2: Mode code 3'd1 sign-extends bits 15:0 of the immediate, adds them to the register and takes bits 23:0 of the sum as the address.
- R3: Mode code 3'd2 adds bits 23:0 of the immediate to the register and takes bits 23:0 of the sum as the address.
- R4: Mode code 3'd3 (post-increment) gives the register's bits 23:0 as the address and a store-back value equal to register plus step, modulo 2^32.
- R5: Mode code 3'd4 (pre-decrement) gives a store-back value equal to register minus step, modulo 2^32, and an address equal to bits 23:0 of that value.
- R6: The step is 1 for size code 2'd0 (byte), 2 for size code 2'd1 (word) and 4 for size code 2'd2 (longword); size code 2'd3 behaves as longword.
- R7: Mode code 3'd5 gives the address {16'hFFFF, immediate bits 7:0}.
- R8: Mode code 3'd6 gives immediate bits 15:0 with bits 23:16 all copies of immediate bit 15.
- R9: Mode code 3'd7 gives the 24-bit immediate unchanged as the address.
- R10: The misalignment flag is high exactly when the size code is not 2'd0 and bit 0 of the produced address is 1; the address and store-back value are produced as usual.
- R11: Store-back enable is high only for mode codes 3'd3 and 3'd4; for every other mode the store-back value equals the register input.
- R12: All outputs show the result for the inputs sampled at the previous rising clock edge; while reset is high at an edge, all outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Addressing-mode code |
| size_i | input | 2 | Access size code |
| reg_i | input | 32 | Contents of the selected address register |
| imm_i | input | 24 | Displacement or absolute address from the instruction |
| ea_o | output | 24 | Operand effective address |
| wb_data_o | output | 32 | Value to store back into the address register |
| wb_en_o | output | 1 | Store-back needed |
| misalign_o | output | 1 | Word or longword access at an odd address |

## Verification
The block holds state only in its output register, so a fault becomes visible at the ports one cycle after the inputs that reveal it. A wrong step shows up at once in the store-back value, and in the address for pre-decrement. A wrong mode decode or extension rule changes the upper address byte, or the bits above it, in that same cycle. The reference model checks every output on every cycle, and the sequences include wrap-around at both ends of the 32-bit range and negative 16-bit values, so a fault in carry, borrow or sign handling cannot hide behind benign data for more than one cycle.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    // Datapath widths
    parameter int unsigned REG_W   = 32;
    parameter int unsigned ADDR_W  = 24;
    parameter int unsigned IMM_W   = ADDR_W;
    parameter int unsigned SHORT_W = 16;
    parameter int unsigned BYTE_W  = 8;

    localparam int unsigned FILL8_W  = ADDR_W - BYTE_W;
    localparam int unsigned FILL16_W = ADDR_W - SHORT_W;

    // Addressing-mode codes; the numeric values are part of the interface
    typedef enum logic [2:0] {
        AM_IND     = 3'd0,
        AM_DISP16  = 3'd1,
        AM_DISP24  = 3'd2,
        AM_POSTINC = 3'd3,
        AM_PREDEC  = 3'd4,
        AM_ABS8    = 3'd5,
        AM_ABS16   = 3'd6,
        AM_ABS24   = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } asize_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [REG_W-1:0]  wb_data;
        logic              wb_en;
        logic              misalign;
    } ea_result_t;

    // Auto-update step for a given access size
    function automatic logic [REG_W-1:0] step_of(asize_e sz);
        logic [REG_W-1:0] s;
        case (sz)
            SZ_BYTE: s = REG_W'(1);
            SZ_WORD: s = REG_W'(2);
            default: s = REG_W'(4);
        endcase
        return s;
    endfunction

    // 16-bit value widened to the address width by sign extension
    function automatic logic [ADDR_W-1:0] sext_short(logic [SHORT_W-1:0] v);
        return {{FILL16_W{v[SHORT_W-1]}}, v};
    endfunction

    // 8-bit absolute address padded with ones
    function automatic logic [ADDR_W-1:0] ones_pad_byte(logic [BYTE_W-1:0] v);
        return {{FILL8_W{1'b1}}, v};
    endfunction

    function automatic logic is_auto_mode(amode_e m);
        return (m == AM_POSTINC) || (m == AM_PREDEC);
    endfunction

endpackage

// File: rtl/opaddr_autostep.sv
module opaddr_autostep
    import opaddr_pkg::*;
(
    input  amode_e            mode,
    input  asize_e            size,
    input  logic [REG_W-1:0]  reg_val,
    output logic [REG_W-1:0]  wb_data,
    output logic              wb_en,
    output logic [ADDR_W-1:0] dec_addr
);

    logic [REG_W-1:0] step;
    logic [REG_W-1:0] inc_val;
    logic [REG_W-1:0] dec_val;

    assign step    = step_of(size);
    assign inc_val = reg_val + step;   // wraps modulo 2^REG_W
    assign dec_val = reg_val - step;

    always_comb begin
        case (mode)
            AM_POSTINC: wb_data = inc_val;
            AM_PREDEC:  wb_data = dec_val;
            default:    wb_data = reg_val;
        endcase
    end

    assign wb_en    = is_auto_mode(mode);
    assign dec_addr = dec_val[ADDR_W-1:0];

endmodule

// File: rtl/opaddr_addr_sel.sv
module opaddr_addr_sel
    import opaddr_pkg::*;
(
    input  amode_e            mode,
    input  logic [ADDR_W-1:0] reg_lo,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic [ADDR_W-1:0] ea
);

    // Low address bits of a sum depend only on low bits of the operands
    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] sum_d16;
    logic [ADDR_W-1:0] sum_d24;

    assign short_ext = sext_short(imm[SHORT_W-1:0]);
    assign sum_d16   = reg_lo + short_ext;
    assign sum_d24   = reg_lo + imm[ADDR_W-1:0];

    always_comb begin
        case (mode)
            AM_IND:     ea = reg_lo;
            AM_DISP16:  ea = sum_d16;
            AM_DISP24:  ea = sum_d24;
            AM_POSTINC: ea = reg_lo;
            AM_PREDEC:  ea = dec_addr;
            AM_ABS8:    ea = ones_pad_byte(imm[BYTE_W-1:0]);
            AM_ABS16:   ea = short_ext;
            AM_ABS24:   ea = imm[ADDR_W-1:0];
            default:    ea = reg_lo;
        endcase
    end

endmodule

// File: rtl/opaddr_align.sv
module opaddr_align
    import opaddr_pkg::*;
(
    input  asize_e size,
    input  logic   ea_lsb,
    output logic   misalign
);

    assign misalign = (size != SZ_BYTE) && ea_lsb;

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [REG_W-1:0]  wb_data_o,
    output logic              wb_en_o,
    output logic              misalign_o
);

    amode_e            mode;
    asize_e            size;
    logic [REG_W-1:0]  wb_data_c;
    logic              wb_en_c;
    logic [ADDR_W-1:0] dec_addr_c;
    logic [ADDR_W-1:0] ea_c;
    logic              mis_c;
    ea_result_t        res_c;
    ea_result_t        res_q;

    assign mode = amode_e'(mode_i);
    assign size = asize_e'(size_i);

    opaddr_autostep u_step (
        .mode     (mode),
        .size     (size),
        .reg_val  (reg_i),
        .wb_data  (wb_data_c),
        .wb_en    (wb_en_c),
        .dec_addr (dec_addr_c)
    );

    opaddr_addr_sel u_sel (
        .mode     (mode),
        .reg_lo   (reg_i[ADDR_W-1:0]),
        .imm      (imm_i),
        .dec_addr (dec_addr_c),
        .ea       (ea_c)
    );

    opaddr_align u_align (
        .size     (size),
        .ea_lsb   (ea_c[0]),
        .misalign (mis_c)
    );

    always_comb begin
        res_c.ea       = ea_c;
        res_c.wb_data  = wb_data_c;
        res_c.wb_en    = wb_en_c;
        res_c.misalign = mis_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_c;
        end
    end

    assign ea_o       = res_q.ea;
    assign wb_data_o  = res_q.wb_data;
    assign wb_en_o    = res_q.wb_en;
    assign misalign_o = res_q.misalign;

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk
    import opaddr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        mode_i,
    input logic [1:0]        size_i,
    input logic [REG_W-1:0]  reg_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [ADDR_W-1:0] ea_o,
    input logic [REG_W-1:0]  wb_data_o,
    input logic              wb_en_o,
    input logic              misalign_o
);

    // High once the previous edge sampled inputs out of reset
    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    AST_WB_EN_AUTO_ONLY: assert property (@(posedge clk) disable iff (rst)
        primed |-> (wb_en_o == ($past(mode_i) == 3'd3 || $past(mode_i) == 3'd4))); // R11

    AST_WB_HOLDS_REG: assert property (@(posedge clk) disable iff (rst)
        (primed && !wb_en_o) |-> (wb_data_o == $past(reg_i))); // R11

    AST_IND_ADDR: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 3'd0) |-> (ea_o == $past(reg_i[ADDR_W-1:0]))); // R1

    AST_POSTINC_OLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 3'd3) |-> (ea_o == $past(reg_i[ADDR_W-1:0]))); // R4

    AST_PREDEC_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 3'd4) |-> (ea_o == wb_data_o[ADDR_W-1:0])); // R5

    AST_ABS8_ONES: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 3'd5) |-> (ea_o[ADDR_W-1:8] == {(ADDR_W-8){1'b1}})); // R7

    AST_ABS24_PASS: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(mode_i) == 3'd7) |-> (ea_o == $past(imm_i))); // R9

    AST_BYTE_NO_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(size_i) == 2'd0) |-> !misalign_o); // R10

    AST_WIDE_ODD_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(size_i) != 2'd0) |-> (misalign_o == ea_o[0])); // R10

endmodule

bind opaddr_gen opaddr_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .size_i     (size_i),
    .reg_i      (reg_i),
    .imm_i      (imm_i),
    .ea_o       (ea_o),
    .wb_data_o  (wb_data_o),
    .wb_en_o    (wb_en_o),
    .misalign_o (misalign_o)
);

// File: tb/opaddr_gen_tb_top.sv
`timescale 1ns/1ps
module opaddr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] reg_i = '0;
    logic [23:0] imm_i = '0;
    logic [23:0] ea_o;
    logic [31:0] wb_data_o;
    logic        wb_en_o;
    logic        misalign_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    opaddr_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i),
        .size_i     (size_i),
        .reg_i      (reg_i),
        .imm_i      (imm_i),
        .ea_o       (ea_o),
        .wb_data_o  (wb_data_o),
        .wb_en_o    (wb_en_o),
        .misalign_o (misalign_o)
    );

    typedef struct {
        int      mode;
        longint  ea;
        longint  wb;
        bit      wb_en;
        bit      mis;
    } exp_t;

    exp_t pending[$];

    function automatic string req_of(int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4/R6";
            4: return "R5/R6";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural reference: integer arithmetic on the requirement text
    function automatic exp_t model(int m, int sz, longint r, longint imm);
        exp_t   e;
        longint step, d;
        step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        e.mode  = m;
        e.wb    = r;
        e.wb_en = 0;
        case (m)
            0: e.ea = r % 64'h1000000;
            1: begin
                d = imm % 65536;
                if (d >= 32768) d = d - 65536;
                e.ea = (r + d + 64'h100000000) % 64'h1000000;
            end
            2: e.ea = (r + imm) % 64'h1000000;
            3: begin
                e.ea = r % 64'h1000000;
                e.wb = (r + step) % 64'h100000000;
                e.wb_en = 1;
            end
            4: begin
                e.wb = (r - step + 64'h100000000) % 64'h100000000;
                e.ea = e.wb % 64'h1000000;
                e.wb_en = 1;
            end
            5: e.ea = 64'hFFFF00 + (imm % 256);
            6: begin
                d = imm % 65536;
                e.ea = (d >= 32768) ? (64'hFF0000 + d) : d;
            end
            default: e.ea = imm;
        endcase
        e.mis = (sz != 0) && (e.ea % 2 == 1);
        return e;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (pending.size() == 0) return;
        e = pending.pop_front();
        check(req_of(e.mode), "ea", longint'(ea_o), e.ea);
        check((e.wb_en ? req_of(e.mode) : "R11"), "wb_data", longint'(wb_data_o), e.wb);
        check("R11", "wb_en", longint'(wb_en_o), longint'(e.wb_en));
        check("R10", "misalign", longint'(misalign_o), longint'(e.mis));
    endtask

    // Apply one input vector at a falling edge; previous result is checked first
    task automatic apply(int m, int sz, longint r, longint imm);
        @(negedge clk);
        compare_out();
        mode_i = m[2:0];
        size_i = sz[1:0];
        reg_i  = r[31:0];
        imm_i  = imm[23:0];
        pending.push_back(model(m, sz, longint'(r[31:0]), longint'(imm[23:0])));
    endtask

    initial begin
        // Reset state, with non-zero inputs present (R12)
        mode_i = 3'd3; size_i = 2'd2; reg_i = 32'h1234_5677; imm_i = 24'hABCDEF;
        repeat (3) @(negedge clk);
        check("R12", "reset ea", longint'(ea_o), 0);
        check("R12", "reset wb_data", longint'(wb_data_o), 0);
        check("R12", "reset wb_en", longint'(wb_en_o), 0);
        check("R12", "reset misalign", longint'(misalign_o), 0);
        rst = 1'b0;
        pending.push_back(model(3, 2, 64'h12345677, 64'hABCDEF));

        // Directed corner cases
        apply(0, 1, 64'hAB12_3457, 0);             // R1, odd word -> R10
        apply(1, 1, 64'h0000_0010, 64'h008000);    // R2 negative disp wraps below zero
        apply(1, 0, 64'h00FF_FFF0, 64'h00_7FFF);   // R2 positive, carry into bit 24 dropped
        apply(2, 2, 64'h0080_0001, 64'hFFFFFF);    // R3
        apply(3, 2, 64'hFFFF_FFFF, 0);             // R4 wrap at top, R6 long step
        apply(3, 0, 64'h0000_1000, 0);             // R6 byte step
        apply(3, 3, 64'h0000_1000, 0);             // R6 reserved size acts as long
        apply(4, 0, 64'h0000_0000, 0);             // R5 borrow wrap to all ones
        apply(4, 1, 64'h0100_0000, 0);             // R5 across 24-bit boundary, R6 word
        apply(5, 0, 64'h1111_1111, 64'h345612);    // R7
        apply(6, 1, 0, 64'h12_8001);               // R8 negative, odd word
        apply(6, 1, 0, 64'hFF_7FFE);               // R8 positive
        apply(7, 2, 64'hDEAD_BEEF, 64'h00_0003);   // R9, misaligned long
        apply(0, 0, 64'h0000_0003, 0);             // R10 byte at odd address

        // Mixed sequences
        for (int i = 0; i < 600; i++) begin
            longint r;
            r = longint'($urandom);
            if (i % 7 == 0) r = 64'hFFFF_FFFC + (i % 4);
            if (i % 11 == 0) r = i % 4;
            apply(int'($urandom % 8), int'($urandom % 4), r, longint'($urandom % 32'h1000000));
        end

        @(negedge clk);
        compare_out();

        // Reset mid-run clears all outputs (R12)
        mode_i = 3'd4; size_i = 2'd1; reg_i = 32'h5; imm_i = '1;
        rst = 1'b1;
        @(negedge clk);
        check("R12", "mid reset ea", longint'(ea_o), 0);
        check("R12", "mid reset wb_en", longint'(wb_en_o), 0);
        check("R12", "mid reset wb_data", longint'(wb_data_o), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule